// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Protection

This block keeps recent virtual-to-physical page translations in a small, fully associative array. On each lookup it compares the virtual page number with every stored tag at the same time. In the same cycle it reports exactly one of three outcomes: a hit with the physical page number, a miss, or a protection fault. A stored entry holds a tag, a physical page number, a valid flag, a dirty flag and four permission flags: readable, writable, executable and user-page. A lookup is checked against the permission that its access type needs and against the current privilege level.

When a lookup misses, a small controller asks an external page table walker for that page. The walker later sends the translation through the refill port. Refill chooses its slot in this order: an entry that already holds the same page, then the lowest invalid entry, then the entry under a first-in-first-out pointer. The pointer moves on only when it is used. A flush, used on a context switch, clears every valid flag and cancels an outstanding walk request. The walk controller has two states. IDLE moves to PENDING on an unflushed miss. PENDING returns to IDLE on a refill or a flush. Otherwise each state holds.

Top module: `tlb_fa_prot`

## Requirements
- R1: After reset every entry is invalid, every lookup misses and `walk_req` is low.
- R2: A lookup whose page is held by a valid entry and is permitted raises `lk_hit` in the same cycle, with that entry's physical page number on `lk_ppn`.
- R3: While `lk_valid` is high exactly one of `lk_hit`, `lk_miss` and `lk_fault` is high. While it is low none of them is high. A page held by no valid entry gives `lk_miss`.
- R4: A miss while IDLE and with no flush makes `walk_req` high from the next cycle, with the missed page on `walk_vpn`. Both hold, and later misses leave them unchanged, until a refill or a flush arrives.
- R5: Access code 0 (read) needs the readable flag, 1 (write) needs the writable flag, and 2 (fetch) needs the executable flag. Code 3 always faults. A missing permission raises `lk_fault`.
- R6: With `lk_user` high the entry's user-page flag must be set. With `lk_user` low the flag must be clear. Otherwise the lookup faults.
- R7: A permitted write to an entry whose dirty flag is clear gives `lk_miss`, not a hit.
- R8: A refill makes its page translate from the next cycle. A refill of a page already held overwrites that entry in place and does not use a second slot.
- R9: Refill fills the lowest-numbered invalid entry while one exists. A flush does not move the replacement pointer.
- R10: When every entry is valid, a refill of a new page replaces the entry under the pointer, and the pointer then moves to the next index, wrapping from the last entry to 0.
- R11: A flush makes every later lookup miss until new refills arrive. A refill in the same cycle as a flush is dropped. A pending walk request is cancelled.
- R12: A permission or privilege fault takes precedence over the dirty-flag miss of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No usable translation |
| lk_fault | output | 1 | Access denied |
| lk_ppn | output | PPN_W | Physical page number on a hit, else 0 |
| walk_req | output | 1 | Page table walk requested |
| walk_vpn | output | VPN_W | Page to be walked |
| rf_valid | input | 1 | Refill strobe |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_ppn | input | PPN_W | Refill physical page number |
| rf_r | input | 1 | Refill readable flag |
| rf_w | input | 1 | Refill writable flag |
| rf_x | input | 1 | Refill executable flag |
| rf_u | input | 1 | Refill user-page flag |
| rf_dirty | input | 1 | Refill dirty flag |

## Verification
The bound checker watches the port-level rules on every cycle. These are: exactly one lookup outcome at a time, how the walk request is raised, held and cancelled, that a flush leaves no hit or fault behind it, and that a page refilled one cycle earlier no longer misses, except on a write whose dirty flag is clear. Other behaviour depends on the stored history and only the directed scenarios can show it. This covers the permission and privilege combinations, fault taking precedence over the dirty miss, overwriting an entry in place, and the replacement order. The replacement order includes lowest-invalid filling and a pointer that keeps its position across a flush.

// File: rtl/tlb_fa_prot_pkg.sv
package tlb_fa_prot_pkg;
    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic usr;
    } perm_t;

    typedef enum logic [0:0] {
        WS_IDLE    = 1'b0,
        WS_PENDING = 1'b1
    } walk_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [VPN_W-1:0]   tags_i [ENTRIES],
    input  logic [VPN_W-1:0]   key_i,
    output logic [ENTRIES-1:0] match_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
    end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_fa_prot_pkg::*;
(
    input  perm_t      perm_i,
    input  logic       dirty_i,
    input  logic [1:0] acc_i,
    input  logic       user_i,
    output logic       allow_o,
    output logic       dirty_miss_o
);
    logic type_ok;
    logic priv_ok;

    always_comb begin
        unique case (acc_i)
            ACC_READ:  type_ok = perm_i.rd;
            ACC_WRITE: type_ok = perm_i.wr;
            ACC_FETCH: type_ok = perm_i.ex;
            default:   type_ok = 1'b0;
        endcase
        priv_ok      = (perm_i.usr == user_i);
        allow_o      = type_ok && priv_ok;
        dirty_miss_o = allow_o && (acc_i == ACC_WRITE) && !dirty_i;
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] same_i,
    input  logic [IDX_W-1:0]   ptr_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               use_ptr_o
);
    logic             any_same;
    logic             any_free;
    logic [IDX_W-1:0] same_idx;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        any_same = 1'b0;
        any_free = 1'b0;
        same_idx = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (same_i[i]) begin
                any_same = 1'b1;
                same_idx = IDX_W'(i);
            end
            if (!valid_i[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        if (any_same) begin
            idx_o     = same_idx;
            use_ptr_o = 1'b0;
        end else if (any_free) begin
            idx_o     = free_idx;
            use_ptr_o = 1'b0;
        end else begin
            idx_o     = ptr_i;
            use_ptr_o = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_fa_prot.sv
module tlb_fa_prot
    import tlb_fa_prot_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [1:0]       lk_acc,
    input  logic             lk_user,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_r,
    input  logic             rf_w,
    input  logic             rf_x,
    input  logic             rf_u,
    input  logic             rf_dirty
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    perm_t              perm_q [ENTRIES];
    logic [IDX_W-1:0]   ptr_q;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] rf_match;
    logic [IDX_W-1:0]   rf_idx;
    logic               rf_use_ptr;
    logic               rf_take;

    logic               any_match;
    perm_t              sel_perm;
    logic               sel_dirty;
    logic [PPN_W-1:0]   sel_ppn;
    logic               allow;
    logic               dirty_miss;

    walk_state_e        state_q;
    walk_state_e        state_d;

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam_lk (
        .valid_i (valid_q),
        .tags_i  (tag_q),
        .key_i   (lk_vpn),
        .match_o (lk_match)
    );

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam_rf (
        .valid_i (valid_q),
        .tags_i  (tag_q),
        .key_i   (rf_vpn),
        .match_o (rf_match)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_i   (valid_q),
        .same_i    (rf_match),
        .ptr_i     (ptr_q),
        .idx_o     (rf_idx),
        .use_ptr_o (rf_use_ptr)
    );

    // Tags are kept unique, so an AND-OR select over the match vector is safe.
    always_comb begin
        any_match = |lk_match;
        sel_perm  = '0;
        sel_dirty = 1'b0;
        sel_ppn   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                sel_perm  = sel_perm | perm_q[i];
                sel_dirty = sel_dirty | dirty_q[i];
                sel_ppn   = sel_ppn | ppn_q[i];
            end
        end
    end

    tlb_perm u_perm (
        .perm_i       (sel_perm),
        .dirty_i      (sel_dirty),
        .acc_i        (lk_acc),
        .user_i       (lk_user),
        .allow_o      (allow),
        .dirty_miss_o (dirty_miss)
    );

    always_comb begin
        lk_hit   = lk_valid && any_match && allow && !dirty_miss;
        lk_fault = lk_valid && any_match && !allow;
        lk_miss  = lk_valid && (!any_match || dirty_miss);
        lk_ppn   = lk_hit ? sel_ppn : '0;
    end

    // Entry array: flush wins over a refill in the same cycle.
    assign rf_take = rf_valid && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ptr_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (rf_take) begin
            valid_q[rf_idx] <= 1'b1;
            dirty_q[rf_idx] <= rf_dirty;
            if (rf_use_ptr) begin
                ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rf_take) begin
            tag_q[rf_idx]  <= rf_vpn;
            ppn_q[rf_idx]  <= rf_ppn;
            perm_q[rf_idx] <= '{rd: rf_r, wr: rf_w, ex: rf_x, usr: rf_u};
        end
    end

    // Walk request controller: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= WS_IDLE;
            walk_vpn <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WS_IDLE && state_d == WS_PENDING) begin
                walk_vpn <= lk_vpn;
            end
        end
    end

    // Walk request controller: next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:    if (!flush && lk_miss) state_d = WS_PENDING;
            WS_PENDING: if (flush || rf_valid) state_d = WS_IDLE;
            default:    state_d = WS_IDLE;
        endcase
    end

    // Walk request controller: outputs.
    always_comb begin
        unique case (state_q)
            WS_PENDING: walk_req = 1'b1;
            default:    walk_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_fa_prot_chk.sv
module tlb_fa_prot_chk #(
    parameter int VPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             lk_valid,
    input logic [VPN_W-1:0] lk_vpn,
    input logic [1:0]       lk_acc,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_fault,
    input logic             walk_req,
    input logic [VPN_W-1:0] walk_vpn,
    input logic             rf_valid,
    input logic [VPN_W-1:0] rf_vpn,
    input logic             rf_dirty
);
    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ($countones({lk_hit, lk_miss, lk_fault}) == 1));

    assert_idle_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    assert_walk_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!walk_req && lk_miss && !flush) |=> (walk_req && walk_vpn == $past(lk_vpn)));

    assert_walk_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !rf_valid && !flush) |=> (walk_req && $stable(walk_vpn)));

    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!walk_req && !lk_hit && !lk_fault));

    assert_refill_installs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rf_valid && !flush) && lk_valid && lk_vpn == $past(rf_vpn))
        |-> (!lk_miss || (lk_acc == 2'd1 && !$past(rf_dirty))));
endmodule

bind tlb_fa_prot tlb_fa_prot_chk #(.VPN_W(VPN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_valid (lk_valid),
    .lk_vpn   (lk_vpn),
    .lk_acc   (lk_acc),
    .lk_hit   (lk_hit),
    .lk_miss  (lk_miss),
    .lk_fault (lk_fault),
    .walk_req (walk_req),
    .walk_vpn (walk_vpn),
    .rf_valid (rf_valid),
    .rf_vpn   (rf_vpn),
    .rf_dirty (rf_dirty)
);

// File: tb/sim_tlb_fa_prot.sv
module sim_tlb_fa_prot;
    localparam int CLK_P   = 10;
    localparam int ENTRIES = 32;
    localparam int VPN_W   = 20;
    localparam int PPN_W   = 22;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             lk_valid = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic [1:0]       lk_acc = 2'd0;
    logic             lk_user = 1'b0;
    logic             lk_hit, lk_miss, lk_fault, walk_req;
    logic [PPN_W-1:0] lk_ppn;
    logic [VPN_W-1:0] walk_vpn;
    logic             rf_valid = 1'b0;
    logic [VPN_W-1:0] rf_vpn = '0;
    logic [PPN_W-1:0] rf_ppn = '0;
    logic             rf_r = 1'b0, rf_w = 1'b0, rf_x = 1'b0, rf_u = 1'b0, rf_dirty = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    tlb_fa_prot #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_ppn(lk_ppn),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
        .rf_r(rf_r), .rf_w(rf_w), .rf_x(rf_x), .rf_u(rf_u), .rf_dirty(rf_dirty)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // outcome code: 4 = hit, 2 = miss, 1 = fault
    task automatic look(input string req, input logic [VPN_W-1:0] vpn, input logic [1:0] acc,
                        input logic usr, input logic [2:0] exp_o, input logic [PPN_W-1:0] exp_ppn);
        @(negedge clk);
        rf_valid = 1'b0; flush = 1'b0;
        lk_valid = 1'b1; lk_vpn = vpn; lk_acc = acc; lk_user = usr;
        #1;
        chk(req, {61'd0, lk_hit, lk_miss, lk_fault}, {61'd0, exp_o});
        if (exp_o == 3'b100) chk(req, 64'(lk_ppn), 64'(exp_ppn));
    endtask

    task automatic refill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                          input logic r, input logic w, input logic x, input logic u,
                          input logic d, input logic with_flush);
        @(negedge clk);
        lk_valid = 1'b0;
        rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn;
        rf_r = r; rf_w = w; rf_x = x; rf_u = u; rf_dirty = d;
        flush = with_flush;
        @(negedge clk);
        rf_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        lk_valid = 1'b0; flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic walk_is(input string req, input logic req_exp, input logic [VPN_W-1:0] vpn_exp);
        @(negedge clk);
        lk_valid = 1'b0;
        #1;
        chk(req, 64'(walk_req), 64'(req_exp));
        if (req_exp) chk(req, 64'(walk_vpn), 64'(vpn_exp));
    endtask

    task automatic t_reset();
        chk("R1 walk_req", 64'(walk_req), 64'd0);
        look("R1 lookup", 20'h0, 2'd0, 1'b0, 3'b010, '0);
        do_flush();
    endtask

    task automatic t_hit();
        refill(20'h00A11, 22'h1234, 1, 1, 1, 0, 1, 0);
        look("R2 R8 read hit", 20'h00A11, 2'd0, 1'b0, 3'b100, 22'h1234);
        look("R2 fetch hit", 20'h00A11, 2'd2, 1'b0, 3'b100, 22'h1234);
        look("R3 other page miss", 20'h00A12, 2'd0, 1'b0, 3'b010, '0);
        do_flush();
    endtask

    task automatic t_walk();
        look("R3 miss", 20'h0BBBB, 2'd0, 1'b0, 3'b010, '0);
        walk_is("R4 walk raised", 1'b1, 20'h0BBBB);
        look("R3 second miss", 20'h0CCCC, 2'd0, 1'b0, 3'b010, '0);
        walk_is("R4 walk held", 1'b1, 20'h0BBBB);
        refill(20'h0BBBB, 22'h0B0, 1, 0, 0, 0, 0, 0);
        chk("R4 walk cleared by refill", 64'(walk_req), 64'd0);
        look("R8 refilled page hits", 20'h0BBBB, 2'd0, 1'b0, 3'b100, 22'h0B0);
    endtask

    task automatic t_perm();
        refill(20'h00100, 22'h100, 1, 0, 0, 0, 1, 0);
        refill(20'h00200, 22'h200, 0, 0, 1, 0, 1, 0);
        look("R5 read ok", 20'h00100, 2'd0, 1'b0, 3'b100, 22'h100);
        look("R5 write denied", 20'h00100, 2'd1, 1'b0, 3'b001, '0);
        look("R5 fetch denied", 20'h00100, 2'd2, 1'b0, 3'b001, '0);
        look("R5 code 3 faults", 20'h00100, 2'd3, 1'b0, 3'b001, '0);
        look("R5 exec-only fetch", 20'h00200, 2'd2, 1'b0, 3'b100, 22'h200);
        look("R5 exec-only read", 20'h00200, 2'd0, 1'b0, 3'b001, '0);
    endtask

    task automatic t_priv();
        refill(20'h00300, 22'h300, 1, 0, 0, 1, 1, 0);
        look("R6 user on user page", 20'h00300, 2'd0, 1'b1, 3'b100, 22'h300);
        look("R6 supervisor on user page", 20'h00300, 2'd0, 1'b0, 3'b001, '0);
        look("R6 user on supervisor page", 20'h00100, 2'd0, 1'b1, 3'b001, '0);
    endtask

    task automatic t_dirty();
        refill(20'h00400, 22'h400, 1, 1, 0, 0, 0, 0);
        look("R7 clean write misses", 20'h00400, 2'd1, 1'b0, 3'b010, '0);
        look("R7 clean read hits", 20'h00400, 2'd0, 1'b0, 3'b100, 22'h400);
        refill(20'h00500, 22'h500, 1, 0, 0, 0, 0, 0);
        look("R12 fault over dirty miss", 20'h00500, 2'd1, 1'b0, 3'b001, '0);
        look("R12 priv fault over dirty miss", 20'h00400, 2'd1, 1'b1, 3'b001, '0);
        refill(20'h00400, 22'h401, 1, 1, 0, 0, 1, 0);
        look("R8 overwrite in place", 20'h00400, 2'd1, 1'b0, 3'b100, 22'h401);
    endtask

    task automatic t_flush();
        do_flush();
        chk("R11 walk cancelled", 64'(walk_req), 64'd0);
        look("R11 flushed page misses", 20'h00100, 2'd0, 1'b0, 3'b010, '0);
        do_flush();
        refill(20'h00600, 22'h600, 1, 1, 1, 0, 1, 1);
        look("R11 refill dropped by flush", 20'h00600, 2'd0, 1'b0, 3'b010, '0);
        do_flush();
    endtask

    task automatic t_fifo();
        for (int i = 0; i < ENTRIES; i++)
            refill(VPN_W'(20'h01000 + i), PPN_W'(22'h1000 + i), 1, 1, 1, 0, 1, 0);
        look("R9 first filled hits", 20'h01000, 2'd0, 1'b0, 3'b100, 22'h1000);
        look("R9 last filled hits", VPN_W'(20'h01000 + ENTRIES - 1), 2'd0, 1'b0, 3'b100,
             PPN_W'(22'h1000 + ENTRIES - 1));
        refill(20'h02000, 22'h2000, 1, 1, 1, 0, 1, 0);
        look("R10 oldest evicted", 20'h01000, 2'd0, 1'b0, 3'b010, '0);
        look("R10 next kept", 20'h01001, 2'd0, 1'b0, 3'b100, 22'h1001);
        look("R10 new page hits", 20'h02000, 2'd0, 1'b0, 3'b100, 22'h2000);
        do_flush();
        for (int i = 0; i < ENTRIES; i++)
            refill(VPN_W'(20'h03000 + i), PPN_W'(22'h3000 + i), 1, 1, 1, 0, 1, 0);
        refill(20'h04000, 22'h4000, 1, 1, 1, 0, 1, 0);
        look("R9 pointer kept across flush, slot 0 kept", 20'h03000, 2'd0, 1'b0, 3'b100, 22'h3000);
        look("R9 pointer kept across flush, slot 1 evicted", 20'h03001, 2'd0, 1'b0, 3'b010, '0);
        look("R10 replacement hits", 20'h04000, 2'd0, 1'b0, 3'b100, 22'h4000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hit();
        t_walk();
        t_perm();
        t_priv();
        t_dirty();
        t_flush();
        t_fifo();
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule